// File: doc/BRIEF.md
# Transmit Packet Queue Start Controller

This block is a byte-wide transmit packet queue placed between an application that writes packets and a MAC that reads them. It holds the bytes in a circular store and decides when the MAC may begin pulling the packet at the head of the queue. The decision follows one of two modes. In store-and-forward mode, a packet is released only after its last byte is in the queue. In cut-through mode, a packet is released once enough bytes of it are buffered to pass a coded level, or earlier if the whole packet is already present.

A small set of configuration fields sets the mode, the enable, the threshold code and the usable queue size. A self-clearing flush command empties the queue. The flush does not take back bytes the MAC has already taken: a packet cut off mid-stream is ended with an underflow pulse. The flush stays busy until every transmit status the MAC has earned has been acknowledged.

Top module: `txq_start_ctrl`

## Requirements
- R1: After reset, the queue is disabled: stEnable reads 0, wrReady is 0, rdValid is 0, rdStart is 0 and stFlushBusy is 0.
- R2: The queue is on only while the enable field holds 2. The values 0, 1 and 3 keep wrReady at 0, and a pulse on rdStart always follows a cycle in which the enable field held 2.
- R3: In cut-through mode (stStoreFwd = 0), rdStart pulses one cycle after the head packet's buffered byte count becomes strictly greater than the level selected by the threshold code. The levels are 0→32, 1→64, 2→96, 3→128, 4→192, 5→256, 6→384 and 7→512 bytes.
- R4: In cut-through mode, a packet whose end marker is in the queue is released one cycle after its end marker is written, even if it never exceeded the threshold.
- R5: In store-and-forward mode (stStoreFwd = 1), the threshold code has no effect, and rdStart pulses only one cycle after the packet's end marker is written.
- R6: Usable capacity is (size code + 1) × 256 bytes. wrReady falls to 0 when the occupancy reaches this capacity. A write offered while wrReady is 0 is discarded, and wrDrop pulses in the next cycle.
- R7: Each packet gets exactly one rdStart, and rdStart never lasts two cycles. The packet then streams in write order until its end marker is taken.
- R8: Writing the flush bit sets stFlushBusy, discards all queued bytes and drops rdValid. A packet that was streaming is cut off with one rdUnderflow pulse. Data written after the flush completes comes out first.
- R9: Each end marker taken by the MAC adds one pending status, and a pulse on statusAck removes one. stFlushBusy clears itself only once the queue is empty and no status is pending.
- R10: Configuration writes offered while stFlushBusy is 1 are ignored in full.
- R11: A configuration write while a packet is streaming updates the other fields but leaves stStoreFwd unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgEnable | input | 2 | Enable field to write (2 = on) |
| cfgStoreFwd | input | 1 | Store-and-forward mode to write |
| cfgThrCode | input | 3 | Threshold code to write |
| cfgSizeCode | input | 3 | Queue size code to write (256-byte units minus one) |
| cfgFlush | input | 1 | Flush command bit |
| stEnable | output | 2 | Enable field readback |
| stStoreFwd | output | 1 | Mode readback |
| stThrCode | output | 3 | Threshold code readback |
| stSizeCode | output | 3 | Size code readback |
| stFlushBusy | output | 1 | Flush in progress (self-clearing) |
| wrValid | input | 1 | Write byte offered |
| wrData | input | 8 | Write byte |
| wrSop | input | 1 | First byte of packet |
| wrEop | input | 1 | Last byte of packet |
| wrReady | output | 1 | Queue can accept a byte |
| wrDrop | output | 1 | Pulse: a write offered last cycle was discarded |
| rdStart | output | 1 | Pulse: head packet released to the MAC |
| rdValid | output | 1 | Head byte available to a started packet |
| rdData | output | 8 | Head byte |
| rdSop | output | 1 | Head byte starts a packet |
| rdEop | output | 1 | Head byte ends a packet |
| rdReady | input | 1 | MAC takes the head byte |
| rdUnderflow | output | 1 | Pulse: a streaming packet was cut off by a flush |
| statusAck | input | 1 | Application acknowledges one transmit status |

## Verification
A wrong byte or packet count inside the block shows up as an rdStart that arrives too early or too late. The bench measures the write count at which the pulse appears, so a level that is off by one byte is caught on the same cycle. A wrong status or flush state shows up as stFlushBusy that clears before the acknowledge or never clears at all, which is visible within two cycles of the acknowledge. Leftover data after a flush appears as the first byte read back from the next packet.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } txqStrobe_t;

  function automatic logic [9:0] thrBytes(input logic [2:0] code);
    logic [9:0] lvl;
    case (code)
      3'd0: lvl = 10'd32;
      3'd1: lvl = 10'd64;
      3'd2: lvl = 10'd96;
      3'd3: lvl = 10'd128;
      3'd4: lvl = 10'd192;
      3'd5: lvl = 10'd256;
      3'd6: lvl = 10'd384;
      default: lvl = 10'd512;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/txq_datapath.sv
module txq_datapath
  import txq_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  txqStrobe_t       strobe,
  input  logic [7:0]       wrData,
  input  logic             wrSop,
  input  logic             wrEop,
  output logic [OCC_W-1:0] occupancy,
  output logic [OCC_W-1:0] completePkts,
  output logic [7:0]       headData,
  output logic             headSop,
  output logic             headEop
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [9:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [9:0] headWord;

  assign headWord = store[rdPtr];
  assign headData = headWord[7:0];
  assign headSop  = headWord[8];
  assign headEop  = headWord[9];

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr] <= {wrEop, wrSop, wrData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr        <= '0;
      rdPtr        <= '0;
      occupancy    <= '0;
      completePkts <= '0;
    end else if (strobe.clear) begin
      wrPtr        <= '0;
      rdPtr        <= '0;
      occupancy    <= '0;
      completePkts <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   occupancy <= occupancy + 1'b1;
        2'b01:   occupancy <= occupancy - 1'b1;
        default: occupancy <= occupancy;
      endcase
      case ({strobe.push && wrEop, strobe.pop && headEop})
        2'b10:   completePkts <= completePkts + 1'b1;
        2'b01:   completePkts <= completePkts - 1'b1;
        default: completePkts <= completePkts;
      endcase
    end
  end

endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import txq_pkg::*;
#(
  parameter int MAX_BLOCKS = 8,
  parameter int OCC_W      = 12,
  parameter int PEND_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgEnable,
  input  logic             cfgStoreFwd,
  input  logic [2:0]       cfgThrCode,
  input  logic [2:0]       cfgSizeCode,
  input  logic             cfgFlush,
  output logic [1:0]       stEnable,
  output logic             stStoreFwd,
  output logic [2:0]       stThrCode,
  output logic [2:0]       stSizeCode,
  output logic             stFlushBusy,
  input  logic             wrValid,
  output logic             wrReady,
  output logic             wrDrop,
  output logic             rdStart,
  output logic             rdValid,
  input  logic             rdReady,
  output logic             rdUnderflow,
  input  logic             statusAck,
  input  logic [OCC_W-1:0] occupancy,
  input  logic [OCC_W-1:0] completePkts,
  input  logic             headEop,
  output txqStrobe_t       strobe
);

  localparam int DEPTH = MAX_BLOCKS * 256;
  localparam logic [1:0] EN_ON = 2'd2;

  logic              streaming;
  logic [PEND_W-1:0] pendCnt;
  logic              enabled, thrHit, startNow, lastTaken, ackTaken;
  logic [31:0]       capLimit;

  assign enabled = (stEnable == EN_ON);

  always_comb begin
    if (32'(stSizeCode) >= 32'(MAX_BLOCKS)) capLimit = 32'(DEPTH);
    else                                    capLimit = (32'(stSizeCode) + 32'd1) << 8;
  end

  assign wrReady   = enabled && !stFlushBusy && (32'(occupancy) < capLimit);
  assign rdValid   = streaming && !stFlushBusy && (occupancy != '0);
  assign thrHit    = !stStoreFwd && (32'(occupancy) > 32'(thrBytes(stThrCode)));
  assign startNow  = !streaming && !stFlushBusy && enabled && (occupancy != '0)
                     && ((completePkts != '0) || thrHit);
  assign lastTaken = rdValid && rdReady && headEop;
  assign ackTaken  = statusAck && (pendCnt != '0);

  assign strobe.push  = wrValid && wrReady;
  assign strobe.pop   = rdValid && rdReady;
  assign strobe.clear = stFlushBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stEnable    <= '0;
      stStoreFwd  <= 1'b0;
      stThrCode   <= '0;
      stSizeCode  <= '0;
      stFlushBusy <= 1'b0;
      streaming   <= 1'b0;
      rdStart     <= 1'b0;
      rdUnderflow <= 1'b0;
      wrDrop      <= 1'b0;
      pendCnt     <= '0;
    end else begin
      rdStart     <= startNow;
      rdUnderflow <= 1'b0;
      wrDrop      <= wrValid && !wrReady;

      case ({lastTaken, ackTaken})
        2'b10:   pendCnt <= pendCnt + 1'b1;
        2'b01:   pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase

      if (stFlushBusy) begin
        if (streaming) begin
          streaming   <= 1'b0;
          rdUnderflow <= 1'b1;
        end
        if ((occupancy == '0) && (pendCnt == '0)) stFlushBusy <= 1'b0;
      end else begin
        if (startNow)       streaming <= 1'b1;
        else if (lastTaken) streaming <= 1'b0;
        if (cfgWe) begin
          stEnable   <= cfgEnable;
          stThrCode  <= cfgThrCode;
          stSizeCode <= cfgSizeCode;
          if (!streaming) stStoreFwd <= cfgStoreFwd;
          if (cfgFlush)   stFlushBusy <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/txq_start_ctrl.sv
module txq_start_ctrl
  import txq_pkg::*;
#(
  parameter int MAX_BLOCKS = 8,
  parameter int PEND_W     = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic [1:0] cfgEnable,
  input  logic       cfgStoreFwd,
  input  logic [2:0] cfgThrCode,
  input  logic [2:0] cfgSizeCode,
  input  logic       cfgFlush,
  output logic [1:0] stEnable,
  output logic       stStoreFwd,
  output logic [2:0] stThrCode,
  output logic [2:0] stSizeCode,
  output logic       stFlushBusy,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  input  logic       wrSop,
  input  logic       wrEop,
  output logic       wrReady,
  output logic       wrDrop,
  output logic       rdStart,
  output logic       rdValid,
  output logic [7:0] rdData,
  output logic       rdSop,
  output logic       rdEop,
  input  logic       rdReady,
  output logic       rdUnderflow,
  input  logic       statusAck
);

  localparam int DEPTH = MAX_BLOCKS * 256;
  localparam int OCC_W = $clog2(DEPTH + 1);

  txqStrobe_t       strobe;
  logic [OCC_W-1:0] occupancy, completePkts;

  txq_ctrl #(.MAX_BLOCKS(MAX_BLOCKS), .OCC_W(OCC_W), .PEND_W(PEND_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgEnable(cfgEnable), .cfgStoreFwd(cfgStoreFwd),
    .cfgThrCode(cfgThrCode), .cfgSizeCode(cfgSizeCode), .cfgFlush(cfgFlush),
    .stEnable(stEnable), .stStoreFwd(stStoreFwd), .stThrCode(stThrCode),
    .stSizeCode(stSizeCode), .stFlushBusy(stFlushBusy),
    .wrValid(wrValid), .wrReady(wrReady), .wrDrop(wrDrop),
    .rdStart(rdStart), .rdValid(rdValid), .rdReady(rdReady),
    .rdUnderflow(rdUnderflow), .statusAck(statusAck),
    .occupancy(occupancy), .completePkts(completePkts), .headEop(rdEop),
    .strobe(strobe)
  );

  txq_datapath #(.DEPTH(DEPTH), .OCC_W(OCC_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(wrData), .wrSop(wrSop), .wrEop(wrEop),
    .occupancy(occupancy), .completePkts(completePkts),
    .headData(rdData), .headSop(rdSop), .headEop(rdEop)
  );

endmodule

// File: rtl/txq_start_ctrl_checker.sv
module txq_start_ctrl_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] stEnable,
  input logic       stStoreFwd,
  input logic [2:0] stThrCode,
  input logic [2:0] stSizeCode,
  input logic       stFlushBusy,
  input logic       wrValid,
  input logic       wrReady,
  input logic       wrDrop,
  input logic       rdStart,
  input logic       rdValid,
  input logic       rdUnderflow
);

  assert_start_needs_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdStart |-> ($past(stEnable) == 2'd2));

  assert_drop_flagged_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> wrDrop);

  assert_single_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdStart |=> !rdStart);

  assert_underflow_from_flush_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdUnderflow |-> $past(stFlushBusy));

  assert_underflow_stops_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdUnderflow |-> !rdValid);

  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    stFlushBusy |=> ($stable(stEnable) && $stable(stThrCode) && $stable(stSizeCode)
                     && $stable(stStoreFwd)));

  assert_mode_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> $stable(stStoreFwd));

endmodule

bind txq_start_ctrl txq_start_ctrl_checker chk_i (
  .clk(clk), .rstN(rstN), .stEnable(stEnable), .stStoreFwd(stStoreFwd),
  .stThrCode(stThrCode), .stSizeCode(stSizeCode), .stFlushBusy(stFlushBusy),
  .wrValid(wrValid), .wrReady(wrReady), .wrDrop(wrDrop), .rdStart(rdStart),
  .rdValid(rdValid), .rdUnderflow(rdUnderflow)
);

// File: tb/txq_start_ctrl_tb_top.sv
module txq_start_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [1:0] cfgEnable = '0;
  logic       cfgStoreFwd = 1'b0;
  logic [2:0] cfgThrCode = '0;
  logic [2:0] cfgSizeCode = '0;
  logic       cfgFlush = 1'b0;
  logic [1:0] stEnable;
  logic       stStoreFwd;
  logic [2:0] stThrCode;
  logic [2:0] stSizeCode;
  logic       stFlushBusy;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic       wrSop = 1'b0;
  logic       wrEop = 1'b0;
  logic       wrReady;
  logic       wrDrop;
  logic       rdStart;
  logic       rdValid;
  logic [7:0] rdData;
  logic       rdSop;
  logic       rdEop;
  logic       rdReady = 1'b0;
  logic       rdUnderflow;
  logic       statusAck = 1'b0;

  int nChecks = 0;
  int nFail = 0;
  int wrCount, startAt, startCnt, underCnt;

  localparam int NV = 9;
  localparam int V_THR [NV] = '{0, 1, 4, 4, 7, 3, 5, 6, 2};
  localparam int V_SF  [NV] = '{0, 0, 0, 1, 0, 0, 0, 0, 0};
  localparam int V_LEN [NV] = '{40, 20, 300, 300, 520, 129, 256, 400, 100};
  localparam int V_EXP [NV] = '{34, 20, 194, 300, 514, 129, 256, 386, 98};

  always #10 clk = ~clk;

  txq_start_ctrl dut_i (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tickMon();
    @(posedge clk);
    @(negedge clk);
    if (rdStart) begin
      startCnt++;
      startAt = wrCount;
    end
    if (rdUnderflow) underCnt++;
  endtask

  task automatic cfgWrite(input int en, input int sf, input int thr, input int sz, input bit fl);
    cfgWe = 1'b1;
    cfgEnable = 2'(en);
    cfgStoreFwd = 1'(sf);
    cfgThrCode = 3'(thr);
    cfgSizeCode = 3'(sz);
    cfgFlush = fl;
    tickMon();
    cfgWe = 1'b0;
    cfgFlush = 1'b0;
  endtask

  task automatic sendPkt(input int len, input int seed, input bit withEop);
    for (int i = 0; i < len; i++) begin
      wrValid = 1'b1;
      wrData = 8'(i * 3 + seed);
      wrSop = (i == 0);
      wrEop = withEop && (i == len - 1);
      if (wrReady) wrCount++;
      tickMon();
    end
    wrValid = 1'b0;
    wrSop = 1'b0;
    wrEop = 1'b0;
  endtask

  task automatic drainPkt(input int len, input int seed, input string tag);
    int got = 0;
    int bad = 0;
    bit done = 0;
    rdReady = 1'b1;
    for (int c = 0; c < len * 2 + 20 && !done; c++) begin
      if (rdValid) begin
        if (rdData != 8'(got * 3 + seed)) bad++;
        if (rdEop) done = 1;
        got++;
      end
      tickMon();
    end
    rdReady = 1'b0;
    check(bad == 0, tag, bad, 0);
    check(got == len, tag, got, len);
  endtask

  task automatic ackOne();
    statusAck = 1'b1;
    tickMon();
    statusAck = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    wrCount = 0; startAt = -1; startCnt = 0; underCnt = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tickMon();

    // R1 reset state
    check(stEnable == 2'd0, "R1 enable", stEnable, 0);
    check(wrReady == 1'b0, "R1 wrReady", wrReady, 0);
    check(rdValid == 1'b0, "R1 rdValid", rdValid, 0);
    check(rdStart == 1'b0, "R1 rdStart", rdStart, 0);
    check(stFlushBusy == 1'b0, "R1 flushBusy", stFlushBusy, 0);

    // R2 reserved enable codes keep the queue off
    cfgWrite(3, 0, 0, 7, 0);
    check(wrReady == 1'b0, "R2 enable=3", wrReady, 0);
    cfgWrite(1, 0, 0, 7, 0);
    check(wrReady == 1'b0, "R2 enable=1", wrReady, 0);
    cfgWrite(2, 0, 0, 7, 0);
    check(wrReady == 1'b1, "R2 enable=2", wrReady, 1);

    // R3/R4/R5 start point per vector, R7 streaming
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = (V_SF[v] != 0) ? "R5 start" : ((V_EXP[v] == V_LEN[v]) ? "R4 start" : "R3 start");
      cfgWrite(2, V_SF[v], V_THR[v], 7, 0);
      wrCount = 0; startAt = -1; startCnt = 0;
      sendPkt(V_LEN[v], v, 1'b1);
      repeat (3) tickMon();
      check(startAt == V_EXP[v], tag, startAt, V_EXP[v]);
      check(startCnt == 1, "R7 one start", startCnt, 1);
      drainPkt(V_LEN[v], v, "R7 stream order");
      tickMon();
      ackOne();
    end

    // R6 capacity with size code 0 (256 bytes)
    cfgWrite(2, 1, 7, 0, 0);
    wrCount = 0;
    sendPkt(255, 5, 1'b0);
    check(wrReady == 1'b1, "R6 ready at 255", wrReady, 1);
    sendPkt(1, 9, 1'b0);
    check(wrReady == 1'b0, "R6 full at 256", wrReady, 0);
    wrValid = 1'b1;
    tickMon();
    wrValid = 1'b0;
    check(wrDrop == 1'b1, "R6 drop flag", wrDrop, 1);
    check(wrCount == 256, "R6 accepted bytes", wrCount, 256);

    // R8 flush with nothing pending
    cfgWrite(2, 1, 7, 0, 1);
    check(stFlushBusy == 1'b1, "R8 busy set", stFlushBusy, 1);
    tickMon();
    tickMon();
    check(stFlushBusy == 1'b0, "R8 self clear", stFlushBusy, 0);
    check(wrReady == 1'b1, "R8 space freed", wrReady, 1);

    // R9 pending status holds flush; R8 underflow; R10 and R11 config rules
    cfgWrite(2, 1, 0, 7, 0);
    sendPkt(10, 64, 1'b1);
    repeat (2) tickMon();
    drainPkt(10, 64, "R9 setup packet");
    cfgWrite(2, 0, 0, 7, 0);
    check(stStoreFwd == 1'b0, "R11 idle mode change", stStoreFwd, 0);
    startCnt = 0;
    sendPkt(50, 128, 1'b0);
    check(startCnt == 1, "R3 partial start", startCnt, 1);
    rdReady = 1'b1;
    repeat (5) tickMon();
    rdReady = 1'b0;
    cfgWrite(2, 1, 3, 7, 0);
    check(stStoreFwd == 1'b0, "R11 mode held", stStoreFwd, 0);
    check(stThrCode == 3'd3, "R11 other field taken", stThrCode, 3);
    underCnt = 0;
    cfgWrite(2, 0, 3, 7, 1);
    check(stFlushBusy == 1'b1, "R8 busy set", stFlushBusy, 1);
    repeat (4) tickMon();
    check(underCnt == 1, "R8 underflow pulse", underCnt, 1);
    check(rdValid == 1'b0, "R8 rdValid dropped", rdValid, 0);
    check(stFlushBusy == 1'b1, "R9 waits for ack", stFlushBusy, 1);
    cfgWrite(2, 1, 6, 2, 0);
    check(stThrCode == 3'd3, "R10 thr ignored", stThrCode, 3);
    check(stSizeCode == 3'd7, "R10 size ignored", stSizeCode, 7);
    ackOne();
    tickMon();
    check(stFlushBusy == 1'b0, "R9 clear after ack", stFlushBusy, 0);
    startCnt = 0;
    sendPkt(5, 192, 1'b1);
    repeat (2) tickMon();
    check(startCnt == 1, "R8 fresh start", startCnt, 1);
    drainPkt(5, 192, "R8 queue emptied");
    ackOne();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule